// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel

This block timestamps transitions on one external input. The input is first brought into the clock domain through two flops. It can then be forced low or inverted, and the result is watched for rising and falling transitions. On each transition it stores the value of a free-running time-base counter, which arrives on an input port. A rising transition stores into one data register and a falling transition into another.

Each edge has its own status flag, which software clears with a one-cycle write-one strobe. Each edge also has a sticky overrun flag that reports a capture arriving before the previous one was acknowledged. A single interrupt line is formed from the two flags, each gated by its own enable. Either edge can also ask the external counter to restart, through a one-cycle reload pulse.

The counter and the register decode sit outside. The top level exposes the control bits as plain inputs and the captured state as plain outputs.

Top module: `dual_edge_capture`

## Requirements
- R1: With `in_en` low the conditioned input level is 0, so pin activity produces no capture, no flag and no reload pulse.
- R2: With `inv_en` high the synchronized pin is inverted before edge detection, so a low pin reads as a high level.
- R3: With `cap_en` low no capture occurs: `rise_data`, `fall_data`, both flags and `reload_pulse` are left unchanged by input edges.
- R4: A rising edge of the conditioned level stores `cnt_val` into `rise_data`, and a falling edge stores it into `fall_data`. The value stored is the one present in the cycle before the storing clock edge.
- R5: A capture sets that edge's flag. A one-cycle high on `rise_clr` / `fall_clr` clears it. If a capture and a clear arrive in the same cycle, the capture wins.
- R6: A capture arriving while that edge's flag is already 1 sets that edge's overrun flag, which then stays set.
- R7: A clear strobe also clears that edge's overrun flag, in the same cycle as the edge flag.
- R8: `reload_pulse` is high for exactly the one cycle after a rising capture with `rise_rl_en` set, or after a falling capture with `fall_rl_en` set.
- R9: `irq` is high exactly when (`rise_flag` and `rise_ie`) or (`fall_flag` and `fall_ie`).
- R10: A pin transition that is set up before clock edge k is captured at edge k+2, so the result is visible after the third clock edge counted from edge k.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 1 | Asynchronous capture input |
| cnt_val | input | 16 | Time-base counter value |
| in_en | input | 1 | Input path enable |
| inv_en | input | 1 | Input inversion enable |
| cap_en | input | 1 | Capture function enable |
| rise_rl_en | input | 1 | Counter reload request on rising capture |
| fall_rl_en | input | 1 | Counter reload request on falling capture |
| rise_ie | input | 1 | Rising-capture interrupt enable |
| fall_ie | input | 1 | Falling-capture interrupt enable |
| rise_clr | input | 1 | Write-one clear strobe for the rising flag |
| fall_clr | input | 1 | Write-one clear strobe for the falling flag |
| rise_data | output | 16 | Counter value at the last rising capture |
| fall_data | output | 16 | Counter value at the last falling capture |
| rise_flag | output | 1 | Rising capture flag |
| fall_flag | output | 1 | Falling capture flag |
| rise_ovr | output | 1 | Rising capture overrun |
| fall_ovr | output | 1 | Falling capture overrun |
| irq | output | 1 | Combined capture interrupt |
| reload_pulse | output | 1 | One-cycle counter reload request |

## Verification
The previous conditioned level is the only hidden state. If it goes wrong, the error appears as a spurious or missing capture: a flag changes, or a data register updates with the wrong counter value, within one cycle of the next input change. If the synchronizer depth is wrong, every capture shifts by a cycle. That shift shows at once in both the stored counter value and the timing of the flag rise. A wrong flag or overrun state shows directly on its port and on `irq` in the cycle after the event or the clear.

// File: rtl/capture_pkg.sv
package capture_pkg;
    localparam int unsigned EDGE_RISE = 0;
    localparam int unsigned EDGE_FALL = 1;
    localparam int unsigned N_EDGES   = 2;

    typedef struct packed {
        logic s1;
        logic s2;
        logic lvl;
    } sync_state_t;
endpackage

// File: rtl/capture_sync_edge.sv
module capture_sync_edge
    import capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic in_en,
    input  logic inv_en,
    output logic rise_evt,
    output logic fall_evt
);
    sync_state_t st_d, st_q;
    logic        lvl_now;

    always_comb begin
        st_d     = st_q;
        lvl_now  = in_en & (st_q.s2 ^ inv_en);
        st_d.s1  = pin;
        st_d.s2  = st_q.s1;
        st_d.lvl = lvl_now;
        rise_evt = lvl_now & ~st_q.lvl;
        fall_evt = ~lvl_now & st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // an edge on the conditioned level is recorded as the new previous level
    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> st_q.lvl);
    // with the path disabled the recorded level drops and stays low
    assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> !st_q.lvl);
endmodule

// File: rtl/capture_edge_slot.sv
module capture_edge_slot #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr,
    output logic [CNT_W-1:0] data,
    output logic             flag,
    output logic             ovr
);
    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic             flag;
        logic             ovr;
    } slot_state_t;

    slot_state_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (evt) sl_d.data = cnt;
        sl_d.flag = evt | (sl_q.flag & ~clr);
        if (clr)                    sl_d.ovr = 1'b0;
        else if (evt && sl_q.flag)  sl_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign data = sl_q.data;
    assign flag = sl_q.flag;
    assign ovr  = sl_q.ovr;

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    assert_ovr_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> flag);
    assert_clear_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!flag && !ovr));
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(data));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import capture_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             in_en,
    input  logic             inv_en,
    input  logic             cap_en,
    input  logic             rise_rl_en,
    input  logic             fall_rl_en,
    input  logic             rise_ie,
    input  logic             fall_ie,
    input  logic             rise_clr,
    input  logic             fall_clr,
    output logic [CNT_W-1:0] rise_data,
    output logic [CNT_W-1:0] fall_data,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             rise_ovr,
    output logic             fall_ovr,
    output logic             irq,
    output logic             reload_pulse
);
    logic                 rise_evt, fall_evt;
    logic [N_EDGES-1:0]   cap_vec, clr_vec, rl_vec, ie_vec, flag_vec, ovr_vec;
    logic [CNT_W-1:0]     data_vec [N_EDGES];
    logic                 reload_d, reload_q;

    capture_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .in_en    (in_en),
        .inv_en   (inv_en),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    assign cap_vec[EDGE_RISE] = rise_evt & cap_en;
    assign cap_vec[EDGE_FALL] = fall_evt & cap_en;
    assign clr_vec[EDGE_RISE] = rise_clr;
    assign clr_vec[EDGE_FALL] = fall_clr;
    assign rl_vec[EDGE_RISE]  = rise_rl_en;
    assign rl_vec[EDGE_FALL]  = fall_rl_en;
    assign ie_vec[EDGE_RISE]  = rise_ie;
    assign ie_vec[EDGE_FALL]  = fall_ie;

    for (genvar e = 0; e < N_EDGES; e++) begin : g_slot
        capture_edge_slot #(.CNT_W(CNT_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (cap_vec[e]),
            .cnt   (cnt_val),
            .clr   (clr_vec[e]),
            .data  (data_vec[e]),
            .flag  (flag_vec[e]),
            .ovr   (ovr_vec[e])
        );
    end

    always_comb begin
        reload_d = |(cap_vec & rl_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reload_q <= 1'b0;
        else        reload_q <= reload_d;
    end

    assign rise_data    = data_vec[EDGE_RISE];
    assign fall_data    = data_vec[EDGE_FALL];
    assign rise_flag    = flag_vec[EDGE_RISE];
    assign fall_flag    = flag_vec[EDGE_FALL];
    assign rise_ovr     = ovr_vec[EDGE_RISE];
    assign fall_ovr     = ovr_vec[EDGE_FALL];
    assign irq          = |(flag_vec & ie_vec);
    assign reload_pulse = reload_q;

    assert_rise_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vec[EDGE_RISE] |=> (rise_data == $past(cnt_val)));
    assert_fall_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vec[EDGE_FALL] |=> (fall_data == $past(cnt_val)));
    assert_reload_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vec[EDGE_RISE] && rise_rl_en) |=> reload_pulse);
    assert_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(rise_data) && $stable(fall_data) && !reload_pulse));
endmodule

// File: tb/test_dual_edge_capture.sv
module test_dual_edge_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        in_en = 0, inv_en = 0, cap_en = 0, rise_rl_en = 0, fall_rl_en = 0;
    logic        rise_ie = 0, fall_ie = 0, rise_clr = 0, fall_clr = 0;
    logic [15:0] rise_data, fall_data;
    logic        rise_flag, fall_flag, rise_ovr, fall_ovr, irq, reload_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_edge_capture i_dual_edge_capture (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cnt_val(cnt_val),
        .in_en(in_en), .inv_en(inv_en), .cap_en(cap_en),
        .rise_rl_en(rise_rl_en), .fall_rl_en(fall_rl_en),
        .rise_ie(rise_ie), .fall_ie(fall_ie),
        .rise_clr(rise_clr), .fall_clr(fall_clr),
        .rise_data(rise_data), .fall_data(fall_data),
        .rise_flag(rise_flag), .fall_flag(fall_flag),
        .rise_ovr(rise_ovr), .fall_ovr(fall_ovr),
        .irq(irq), .reload_pulse(reload_pulse)
    );

    // reference model, built from the requirements
    logic        m_s1, m_s2, m_lvl, m_rf, m_ff, m_ro, m_fo, m_rl;
    logic [15:0] m_rd, m_fd;

    function automatic logic exp_irq(logic rf, logic ff, logic rie, logic fie);
        return (rf & rie) | (ff & fie);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_rf = 0; m_ff = 0;
            m_ro = 0; m_fo = 0; m_rl = 0; m_rd = '0; m_fd = '0;
        end else begin
            logic lv, rc, fc;
            lv = in_en & (m_s2 ^ inv_en);
            rc = cap_en & lv & ~m_lvl;
            fc = cap_en & ~lv & m_lvl;
            if (rise_clr) m_ro = 0; else if (rc && m_rf) m_ro = 1;
            if (fall_clr) m_fo = 0; else if (fc && m_ff) m_fo = 1;
            m_rf = rc | (m_rf & ~rise_clr);
            m_ff = fc | (m_ff & ~fall_clr);
            if (rc) m_rd = cnt_val;
            if (fc) m_fd = cnt_val;
            m_rl = (rc & rise_rl_en) | (fc & fall_rl_en);
            m_lvl = lv;
            m_s2 = m_s1;
            m_s1 = cap_pin;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(2);
        rst_n = 1;
        step(1);
        // R11 reset state
        chk("R11", "rise_data", rise_data, 0);
        chk("R11", "fall_data", fall_data, 0);
        chk("R11", "flags", {rise_flag, fall_flag, rise_ovr, fall_ovr}, 0);
        chk("R11", "irq/reload", {irq, reload_pulse}, 0);

        // R10 latency and R4 rising store, R9 interrupt
        in_en = 1; cap_en = 1; rise_ie = 1; cnt_val = 16'h1234;
        step(3);
        cap_pin = 1;
        step(2);
        chk("R10", "flag before third edge", rise_flag, 0);
        step(1);
        chk("R10", "flag on third edge", rise_flag, 1);
        chk("R4", "rise_data", rise_data, 16'h1234);
        chk("R9", "irq rising", irq, 1);

        // R4 falling store, then R6 overrun
        cap_pin = 0; cnt_val = 16'h0BEE;
        step(3);
        chk("R4", "fall_data", fall_data, 16'h0BEE);
        chk("R4", "fall_flag", fall_flag, 1);
        cap_pin = 1; cnt_val = 16'h2222;
        step(3);
        chk("R4", "rise_data second", rise_data, 16'h2222);
        chk("R6", "rise_ovr", rise_ovr, 1);
        chk("R6", "fall_ovr", fall_ovr, 0);

        // R5, R7 clear; R9 with fall interrupt disabled
        rise_clr = 1;
        step(1);
        rise_clr = 0;
        chk("R5", "rise_flag cleared", rise_flag, 0);
        chk("R7", "rise_ovr cleared", rise_ovr, 0);
        chk("R9", "irq masked fall", irq, 0);

        // R3 capture disabled
        cap_en = 0; cap_pin = 0; cnt_val = 16'h3333;
        step(4);
        chk("R3", "fall_data held", fall_data, 16'h0BEE);
        chk("R3", "fall_ovr held", fall_ovr, 0);
        cap_pin = 1;
        step(4);
        chk("R3", "rise_data held", rise_data, 16'h2222);
        chk("R3", "rise_flag held", rise_flag, 0);

        // R8 reload on falling capture
        cap_en = 1; fall_rl_en = 1; cap_pin = 0; cnt_val = 16'h5A5A;
        step(2);
        chk("R8", "no pulse early", reload_pulse, 0);
        step(1);
        chk("R8", "pulse", reload_pulse, 1);
        chk("R8", "fall_data before reload", fall_data, 16'h5A5A);
        step(1);
        chk("R8", "pulse ends", reload_pulse, 0);
        fall_rl_en = 0;

        // R1 disabled input path
        rise_clr = 1; fall_clr = 1;
        step(1);
        rise_clr = 0; fall_clr = 0; in_en = 0;
        for (int i = 0; i < 6; i++) begin
            cap_pin = ~cap_pin;
            step(3);
        end
        chk("R1", "flags", {rise_flag, fall_flag}, 0);
        chk("R1", "reload", reload_pulse, 0);

        // R2 inversion: pin low reads as high
        cap_pin = 0;
        step(3);
        in_en = 1; inv_en = 1; cnt_val = 16'h4444;
        step(1);
        chk("R2", "rise_flag", rise_flag, 1);
        chk("R2", "rise_data", rise_data, 16'h4444);

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0) cap_pin = ~cap_pin;
            cnt_val = 16'($urandom);
            rise_clr = ($urandom_range(7) == 0);
            fall_clr = ($urandom_range(7) == 0);
            if ($urandom_range(63) == 0) begin
                in_en = ($urandom_range(7) != 0);
                inv_en = 1'($urandom);
                cap_en = ($urandom_range(7) != 0);
                rise_rl_en = 1'($urandom);
                fall_rl_en = 1'($urandom);
                rise_ie = 1'($urandom);
                fall_ie = 1'($urandom);
            end
            step(1);
            chk("R4", "rise_data", rise_data, m_rd);
            chk("R4", "fall_data", fall_data, m_fd);
            chk("R5", "flags", {rise_flag, fall_flag}, {m_rf, m_ff});
            chk("R6", "overruns", {rise_ovr, fall_ovr}, {m_ro, m_fo});
            chk("R8", "reload", reload_pulse, m_rl);
            chk("R9", "irq", irq, exp_irq(m_rf, m_ff, rise_ie, fall_ie));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule